// File: doc/BRIEF.md
# Multicast Destination Hash Filter

This block decides whether a received frame's group destination address should be kept. The six destination address bytes arrive one per accepted cycle. As they arrive, a reflected CRC-32 is folded over them. When the last byte lands, the top bits of the inverted CRC form an index into a 64-bit bitmap, and the addressed bit gives the verdict. The verdict is presented on `match` together with a one-cycle `done` strobe, and it stays on `match` until the next address begins.

Software loads the bitmap as two 32-bit words through a small write port with byte enables. In the same address space it sets a single enable bit that gates all multicast acceptance. Filling both words with ones accepts every group address. A driver builds a selective filter by running the same CRC over each wanted address and setting the resulting bits. Unicast and broadcast recognition and the rest of the receive path sit outside this block.

Top module: `mcast_hash_filter`

## Requirements
- R1: The CRC is the reflected CRC-32. It uses polynomial constant 0xEDB88320 with right shifts, takes each byte least significant bit first and is preset to all ones. It runs over the six address bytes in arrival order, and the final value is inverted.
- R2: The hash index is bits 31:26 of the inverted CRC. Index bit 5 picks the table word: 0 selects the word at write address 0, 1 selects the word at write address 1. Index bits 4:0 pick the bit within that word.
- R3: An address whose first byte has bit 0 clear is never a match, whatever the table holds.
- R4: When the enable bit (write address 2, data bit 0) is clear, no address is a match.
- R5: With the enable set and both table words all ones, every address whose first byte has bit 0 set is a match.
- R6: `done` is high for exactly the one cycle after the sixth byte is accepted, and `match` carries the verdict in that same cycle.
- R7: `match` keeps its value after `done` until the next start. Bytes offered with `addr_valid` after the sixth byte and before a new start are ignored: they raise no `done` and leave `match` unchanged.
- R8: Cycles with `addr_valid` low between bytes stall the sequence without corrupting it. A valid byte without `addr_start` while no address is in progress is ignored.
- R9: A byte with `addr_start` and `addr_valid` both high is byte 0 of a new address, and it clears `match` at that clock edge.
- R10: Write byte enable bit k updates only data bits 8k+7..8k of the addressed word. Reset clears both table words and the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 2 | 0: table word low, 1: table word high, 2: control |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_be | input | 4 | Byte enables for the write |
| addr_start | input | 1 | Marks the first byte of an address |
| addr_valid | input | 1 | Byte on `addr_byte` is offered this cycle |
| addr_byte | input | 8 | Destination address byte, first byte first |
| match | output | 1 | Accept verdict, held until next start |
| done | output | 1 | One-cycle strobe when the verdict is ready |

## Verification
The hardest situation to reach from the ports is a verdict that depends on one bitmap bit. A filter with only the hashed bit set must accept the address, and a filter with every bit except that one set must reject it. Both must hold for addresses whose index lands in either word. The bench computes each address's index with its own bitwise CRC model. It then writes exactly that bit, or its complement, and writes through partial byte enables that skip the addressed lane, so a wrong word select, wrong bit order or wrong lane mapping shows up as a wrong verdict.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   localparam int CRC_W = 32;
   typedef logic [CRC_W-1:0] crc_t;
   localparam crc_t CRC_PRESET = '1;
   localparam crc_t CRC_POLY_REFL = 32'hEDB8_8320;
endpackage

// File: rtl/mhf_crc_step.sv
module mhf_crc_step
   import mhf_pkg::*;
#(
   parameter crc_t POLY = CRC_POLY_REFL
) (
   input  crc_t       crc_in,
   input  logic [7:0] data,
   output crc_t       crc_out
);
   // one byte folded in, least significant bit first, eight shift stages
   always_comb begin
      crc_t c;
      c = crc_in;
      for (int b = 0; b < 8; b++) begin
         c = (c >> 1) ^ (((c[0] ^ data[b]) == 1'b1) ? POLY : '0);
      end
      crc_out = c;
   end
endmodule

// File: rtl/mhf_addr_seq.sv
module mhf_addr_seq #(
   parameter int ADDR_BYTES = 6,
   localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic valid,
   output logic take,
   output logic first,
   output logic last
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pos;

   assign pos   = start ? '0 : cnt_q;
   assign take  = valid && (start || (cnt_q < CNT_W'(ADDR_BYTES)));
   assign first = valid && start;
   assign last  = take && (pos == CNT_W'(ADDR_BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= CNT_W'(ADDR_BYTES);
      else if (take)
         cnt_q <= pos + 1'b1;
   end

   // R7: the byte counter never runs past the address length
   p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(ADDR_BYTES));

   // R8: with no address open, only a start byte is taken
   p_idle_start_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(ADDR_BYTES) && take) |-> start);
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
   parameter int WORD_W = 32,
   parameter int WORDS  = 2,
   localparam int LANES = WORD_W / 8,
   localparam int IDX_W = $clog2(WORD_W * WORDS),
   localparam int CFG_AW = $clog2(WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CFG_AW-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [LANES-1:0]  wr_be,
   input  logic [IDX_W-1:0]  idx,
   output logic              bit_out
);
   logic [WORD_W*WORDS-1:0] flat;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic              hit;
      assign hit = wr_en && (wr_addr == CFG_AW'(w));

      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (hit) begin
            for (int l = 0; l < LANES; l++) begin
               if (wr_be[l]) word_q[l*8 +: 8] <= wr_data[l*8 +: 8];
            end
         end
      end

      assign flat[w*WORD_W +: WORD_W] = word_q;

      // R10: a write with no lane enabled leaves the word alone
      p_no_lane_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && wr_be == '0) |=> $stable(word_q));
   end

   // upper index bits pick the word, lower bits the bit inside it
   assign bit_out = flat[idx];
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
   import mhf_pkg::*;
#(
   parameter int HASH_BITS  = 6,
   parameter int WORD_W     = 32,
   parameter int ADDR_BYTES = 6,
   localparam int WORDS  = (1 << HASH_BITS) / WORD_W,
   localparam int LANES  = WORD_W / 8,
   localparam int CFG_AW = $clog2(WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [CFG_AW-1:0] cfg_wr_addr,
   input  logic [WORD_W-1:0] cfg_wr_data,
   input  logic [LANES-1:0]  cfg_wr_be,
   input  logic              addr_start,
   input  logic              addr_valid,
   input  logic [7:0]        addr_byte,
   output logic              match,
   output logic              done
);
   if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
      $error("WORD_W must be a positive multiple of 8");
   end
   if (HASH_BITS > CRC_W || (1 << HASH_BITS) < WORD_W) begin : g_bad_hash
      $error("HASH_BITS must fit the CRC and cover at least one word");
   end
   if (ADDR_BYTES < 2) begin : g_bad_len
      $error("ADDR_BYTES must be at least 2");
   end

   logic take, first, last;
   crc_t crc_q, crc_seed, crc_next, crc_final;
   logic mc_q, en_q, match_q, done_q, mc_now, tbl_bit;
   logic [HASH_BITS-1:0] idx;

   mhf_addr_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(addr_start), .valid(addr_valid),
      .take(take), .first(first), .last(last)
   );

   assign crc_seed = first ? CRC_PRESET : crc_q;

   mhf_crc_step #(.POLY(CRC_POLY_REFL)) u_crc (
      .crc_in(crc_seed), .data(addr_byte), .crc_out(crc_next)
   );

   assign crc_final = ~crc_next;
   assign idx       = crc_final[CRC_W-1 -: HASH_BITS];
   assign mc_now    = first ? addr_byte[0] : mc_q;

   mhf_hash_table #(.WORD_W(WORD_W), .WORDS(WORDS)) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
      .wr_data(cfg_wr_data), .wr_be(cfg_wr_be), .idx(idx), .bit_out(tbl_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (cfg_wr_en && cfg_wr_addr == CFG_AW'(WORDS) && cfg_wr_be[0]) begin
         en_q <= cfg_wr_data[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q   <= CRC_PRESET;
         mc_q    <= 1'b0;
         match_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         if (take) crc_q <= crc_next;
         if (first) mc_q <= addr_byte[0];
         if (last)
            match_q <= en_q && mc_now && tbl_bit;
         else if (first)
            match_q <= 1'b0;
      end
   end

   assign match = match_q;
   assign done  = done_q;

   // R6: the completion strobe lasts one cycle
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R7: the verdict only moves on completion or on a new start
   p_match_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (match_q != $past(match_q)) |-> (done_q || $past(first)));

   // R3: a reported match belongs to a group address
   p_match_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && match_q) |-> mc_q);

   // R4: a reported match needs the enable set when the verdict formed
   p_match_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && match_q) |-> $past(en_q));
endmodule

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [1:0]  cfg_wr_addr = '0;
   logic [31:0] cfg_wr_data = '0;
   logic [3:0]  cfg_wr_be = '0;
   logic        addr_start = 1'b0;
   logic        addr_valid = 1'b0;
   logic [7:0]  addr_byte = '0;
   logic        match, done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   mcast_hash_filter dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
      .cfg_wr_data(cfg_wr_data), .cfg_wr_be(cfg_wr_be), .addr_start(addr_start),
      .addr_valid(addr_valid), .addr_byte(addr_byte), .match(match), .done(done)
   );

   function automatic logic [5:0] ref_idx(input logic [47:0] a);
      logic [31:0] c;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         logic [7:0] b;
         b = a[47-8*i -: 8];
         for (int k = 0; k < 8; k++) begin
            if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB8_8320;
            else             c = c >> 1;
         end
      end
      c = ~c;
      return c[31:26];
   endfunction

   task automatic chk(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d; cfg_wr_be = be;
      @(negedge clk);
      cfg_wr_en = 1'b0; cfg_wr_be = '0;
   endtask

   // leaves the bench at the negedge right after the done edge
   task automatic send(input logic [47:0] a, input int gap);
      for (int i = 0; i < 6; i++) begin
         if (i > 0) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               addr_valid = 1'b0; addr_start = 1'b0; addr_byte = 8'hA5;
            end
         end
         @(negedge clk);
         addr_valid = 1'b1; addr_start = (i == 0); addr_byte = a[47-8*i -: 8];
      end
      @(negedge clk);
      addr_valid = 1'b0; addr_start = 1'b0;
   endtask

   localparam logic [47:0] MC0 = 48'h01_00_5E_00_00_01;
   localparam logic [47:0] MC1 = 48'h33_33_00_00_00_01;
   localparam logic [47:0] MC2 = 48'h01_80_C2_00_00_0E;
   localparam logic [47:0] MC3 = 48'hFF_FF_FF_FF_FF_FF;
   localparam logic [47:0] UC0 = 48'h00_11_22_33_44_55;

   function automatic logic [47:0] pick(input int n);
      case (n)
         0: return MC0;
         1: return MC1;
         2: return MC2;
         default: return MC3;
      endcase
   endfunction

   task automatic t_reset();
      chk(done, 1'b0, "R10 done low after reset");
      chk(match, 1'b0, "R10 match low after reset");
      wr(2'd2, 32'h1, 4'h1);
      send(MC0, 0);
      chk(done, 1'b1, "R6 done after sixth byte");
      chk(match, 1'b0, "R10 cleared table rejects");
   endtask

   task automatic t_all_ones();
      wr(2'd0, 32'hFFFF_FFFF, 4'hF);
      wr(2'd1, 32'hFFFF_FFFF, 4'hF);
      for (int n = 0; n < 4; n++) begin
         send(pick(n), 0);
         chk(done, 1'b1, "R6 done strobe");
         chk(match, 1'b1, "R5 all-ones accepts group address");
         @(negedge clk);
         chk(done, 1'b0, "R6 done lasts one cycle");
      end
   endtask

   task automatic t_unicast();
      send(UC0, 0);
      chk(done, 1'b1, "R6 done for individual address");
      chk(match, 1'b0, "R3 individual address rejected");
   endtask

   task automatic t_disable();
      wr(2'd2, 32'h0, 4'h1);
      send(MC0, 0);
      chk(match, 1'b0, "R4 disabled rejects");
      wr(2'd2, 32'h1, 4'h1);
      send(MC0, 0);
      chk(match, 1'b1, "R4 re-enabled accepts");
   endtask

   task automatic t_single_bit();
      for (int n = 0; n < 4; n++) begin
         logic [5:0] ix;
         logic [31:0] one;
         ix  = ref_idx(pick(n));
         one = 32'h1 << ix[4:0];
         wr(2'd0, ix[5] ? 32'h0 : one, 4'hF);
         wr(2'd1, ix[5] ? one : 32'h0, 4'hF);
         send(pick(n), 0);
         chk(match, 1'b1, $sformatf("R1 R2 only hashed bit %0d set", ix));
         wr(2'd0, ix[5] ? 32'hFFFF_FFFF : ~one, 4'hF);
         wr(2'd1, ix[5] ? ~one : 32'hFFFF_FFFF, 4'hF);
         send(pick(n), 0);
         chk(match, 1'b0, $sformatf("R1 R2 all but hashed bit %0d set", ix));
      end
   endtask

   task automatic t_byte_en();
      logic [5:0] ix;
      logic [3:0] lane;
      ix   = ref_idx(MC1);
      lane = 4'h1 << ix[4:3];
      wr(2'd0, 32'h0, 4'hF);
      wr(2'd1, 32'h0, 4'hF);
      wr({1'b0, ix[5]}, 32'hFFFF_FFFF, ~lane);
      send(MC1, 0);
      chk(match, 1'b0, "R10 disabled lane left clear");
      wr({1'b0, ix[5]}, 32'hFFFF_FFFF, lane);
      send(MC1, 0);
      chk(match, 1'b1, "R10 enabled lane written");
   endtask

   task automatic t_hold_and_gap();
      wr(2'd0, 32'hFFFF_FFFF, 4'hF);
      wr(2'd1, 32'hFFFF_FFFF, 4'hF);
      // stray bytes while idle, then a gapped address
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         addr_valid = 1'b1; addr_start = 1'b0; addr_byte = 8'h00;
      end
      @(negedge clk);
      addr_valid = 1'b0;
      chk(done, 1'b0, "R8 idle bytes raise no done");
      send(MC2, 2);
      chk(done, 1'b1, "R8 gapped address completes");
      chk(match, 1'b1, "R8 gapped address verdict");
      for (int i = 0; i < 3; i++) begin
         addr_valid = 1'b1; addr_start = 1'b0; addr_byte = 8'h00;
         @(negedge clk);
         chk(done, 1'b0, "R7 extra byte gives no done");
         chk(match, 1'b1, "R7 match held over extra bytes");
      end
      addr_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(match, 1'b1, "R7 match held while idle");
   endtask

   task automatic t_restart();
      @(negedge clk);
      addr_valid = 1'b1; addr_start = 1'b1; addr_byte = UC0[47:40];
      @(negedge clk);
      addr_start = 1'b0;
      chk(match, 1'b0, "R9 start clears match");
      for (int i = 1; i < 6; i++) begin
         addr_byte = UC0[47-8*i -: 8];
         @(negedge clk);
      end
      addr_valid = 1'b0;
      chk(done, 1'b1, "R9 restarted address completes");
      chk(match, 1'b0, "R9 restarted verdict");
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_all_ones();
      t_unicast();
      t_disable();
      t_single_bit();
      t_byte_en();
      t_hold_and_gap();
      t_restart();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end
endmodule